// File: doc/BRIEF.md
# Serial-In Shift Register with Parallel Storage Stage

This block is a serial-to-parallel converter with two ranks. A shift chain takes one serial bit on each rising edge of its own clock. A separate storage rank copies the whole chain on each rising edge of a second clock and drives the parallel outputs. Because of this split, the parallel word changes only when the storage clock says so, even while new bits are being shifted in.

The last stage of the shift chain drives a cascade output. Connecting that output to the serial input of another copy lengthens the chain by `WIDTH` bits. Each rank has its own active-low clear. A clear takes effect at once and overrides that rank's clock. On release, the clear passes through a short synchroniser in the rank's own clock domain, so the rank restarts cleanly on a later edge.

If both clocks are driven from one net, the storage rank always holds the shift chain as it stood one edge earlier.

Top module: `sps_shift_store`

## Requirements
- R1: While `sh_clr_n` is low, the shift chain holds all zeros at once, whatever the clocks and `ser_in` do. So `casc_out` is 0, and a storage capture copies 0.
- R2: On a rising `sh_clk` edge with the shift chain active, stage 0 takes `ser_in` and stage i takes the old stage i-1. Stage 0 is the bit that appears at `par_q[0]`.
- R3: On a rising `st_clk` edge with the storage rank active, `par_q` becomes the shift chain contents from just before that edge. A `sh_clk` edge alone never changes `par_q`.
- R4: While `st_clr_n` is low, `par_q` is all zeros at once. The shift chain is not affected, and `casc_out` keeps its value.
- R5: `casc_out` equals the last shift stage (`WIDTH-1`). It takes its new value right after a shift edge, so the first bit shifted in reaches `casc_out` after `WIDTH` edges.
- R6: With `sh_clk` and `st_clk` driven together, each capture shows the shift chain state from one edge earlier.
- R7: After a clear is released, the first `SYNC_STAGES` rising edges of that rank's clock leave the rank unchanged. The next edge operates normally. Edges that come while the clear is low have no effect.
- R8: When one block's `casc_out` feeds a second block's `ser_in`, with shared clocks and clears, the pair acts as one chain of 2×`WIDTH` bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ser_in | input | 1 | Serial data into shift stage 0 |
| sh_clk | input | 1 | Shift chain clock, rising edge |
| sh_clr_n | input | 1 | Shift chain clear, active low, asynchronous assert |
| st_clk | input | 1 | Storage rank clock, rising edge |
| st_clr_n | input | 1 | Storage rank clear, active low, asynchronous assert |
| par_q | output | WIDTH | Storage rank contents; bit 0 is the first stage |
| casc_out | output | 1 | Last shift stage, for chaining |

## Verification
Random bytes are shifted in full and then captured. This tells apart the shift direction and the bit order at `par_q`. Shift-only edges are checked against an unchanged `par_q`, which separates the two clock domains.

A run with both clocks tied shows the one-edge lag between the ranks. Clears asserted in the middle of a sequence, followed by shifting and capturing right after release, expose the immediate clearing and the restart delay. A second copy driven from `casc_out` shows that data crosses cleanly from one device to the next.

// File: rtl/sps_pkg.sv
package sps_pkg;
   localparam int unsigned SPS_WIDTH_DFLT = 8;
   localparam int unsigned SPS_SYNC_DFLT  = 2;
   localparam int unsigned SPS_SYNC_MAX   = 4;
endpackage

// File: rtl/sps_clr_sync.sv
// Clear conditioner: asserts asynchronously, releases after STAGES edges.
module sps_clr_sync #(
   parameter int unsigned STAGES = sps_pkg::SPS_SYNC_DFLT
) (
   input  logic clk,
   input  logic clr_n,
   output logic rel_n
);
   logic [STAGES-1:0] pipe;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         logic d;
         if (i == 0) begin : g_head
            assign d = 1'b1;
         end else begin : g_tail
            assign d = pipe[i-1];
         end
         always_ff @(posedge clk or negedge clr_n) begin
            if (!clr_n) pipe[i] <= 1'b0;
            else        pipe[i] <= d;
         end
      end
   endgenerate

   assign rel_n = pipe[STAGES-1];

   // R7: a clear seen low at an edge keeps the rank held
   a_r7_clear_holds: assert property (@(posedge clk) !clr_n |-> !rel_n);
endmodule

// File: rtl/sps_shift_chain.sv
module sps_shift_chain #(
   parameter int unsigned WIDTH = sps_pkg::SPS_WIDTH_DFLT
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             din,
   output logic [WIDTH-1:0] stages
);
   localparam int unsigned TOP = WIDTH - 1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stages <= '0;
      else        stages <= {stages[TOP-1:0], din};
   end

   // R1: held clear means an empty chain at the edge
   a_r1_shift_clear: assert property (@(posedge clk) !rst_n |-> stages == '0);
   // R2: first stage takes the serial bit
   a_r2_first_stage: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> stages[0] == $past(din));
   // R2: every other stage takes its neighbour
   a_r2_move_up: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> stages[TOP:1] == $past(stages[TOP-1:0]));
endmodule

// File: rtl/sps_store_bank.sv
module sps_store_bank #(
   parameter int unsigned WIDTH = sps_pkg::SPS_WIDTH_DFLT
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= d;
   end

   // R4: held clear means an empty storage rank
   a_r4_store_clear: assert property (@(posedge clk) !rst_n |-> q == '0);
   // R3: capture copies the chain as it stood before the edge
   a_r3_capture: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> q == $past(d));
endmodule

// File: rtl/sps_shift_store.sv
module sps_shift_store #(
   parameter int unsigned WIDTH       = sps_pkg::SPS_WIDTH_DFLT,
   parameter int unsigned SYNC_STAGES = sps_pkg::SPS_SYNC_DFLT
) (
   input  logic             ser_in,
   input  logic             sh_clk,
   input  logic             sh_clr_n,
   input  logic             st_clk,
   input  logic             st_clr_n,
   output logic [WIDTH-1:0] par_q,
   output logic             casc_out
);
   localparam int unsigned LAST = WIDTH - 1;

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("sps_shift_store: WIDTH must be at least 2");
      end
      if (SYNC_STAGES < 1 || SYNC_STAGES > sps_pkg::SPS_SYNC_MAX) begin : g_bad_sync
         $error("sps_shift_store: SYNC_STAGES out of range");
      end
   endgenerate

   logic             sh_rst_n;
   logic             st_rst_n;
   logic [WIDTH-1:0] chain;

   sps_clr_sync #(.STAGES(SYNC_STAGES)) u_sh_sync (
      .clk   (sh_clk),
      .clr_n (sh_clr_n),
      .rel_n (sh_rst_n)
   );

   sps_clr_sync #(.STAGES(SYNC_STAGES)) u_st_sync (
      .clk   (st_clk),
      .clr_n (st_clr_n),
      .rel_n (st_rst_n)
   );

   sps_shift_chain #(.WIDTH(WIDTH)) u_chain (
      .clk    (sh_clk),
      .rst_n  (sh_rst_n),
      .din    (ser_in),
      .stages (chain)
   );

   sps_store_bank #(.WIDTH(WIDTH)) u_store (
      .clk   (st_clk),
      .rst_n (st_rst_n),
      .d     (chain),
      .q     (par_q)
   );

   // R5: cascade taken from the last shift stage, not the storage rank
   assign casc_out = chain[LAST];
endmodule

// File: tb/sps_shift_store_tb.sv
module sps_shift_store_tb_top;
   localparam int W    = 8;
   localparam int SYNC = 2;

   logic clk = 1'b0;
   always #10 clk = ~clk;   // 50 MHz housekeeping clock

   logic ser_in = 1'b0, sh_clk = 1'b0, st_clk = 1'b0;
   logic sh_clr_n = 1'b0, st_clr_n = 1'b0;
   logic [W-1:0] par_q, par2;
   logic casc_out, casc2;

   sps_shift_store #(.WIDTH(W), .SYNC_STAGES(SYNC)) dut_i (
      .ser_in(ser_in), .sh_clk(sh_clk), .sh_clr_n(sh_clr_n),
      .st_clk(st_clk), .st_clr_n(st_clr_n), .par_q(par_q), .casc_out(casc_out));

   sps_shift_store #(.WIDTH(W), .SYNC_STAGES(SYNC)) dut2_i (
      .ser_in(casc_out), .sh_clk(sh_clk), .sh_clr_n(sh_clr_n),
      .st_clk(st_clk), .st_clr_n(st_clr_n), .par_q(par2), .casc_out(casc2));

   int checks = 0, errors = 0;
   logic [W-1:0] sh_m = '0, sh2_m = '0, st_m = '0, st2_m = '0;
   int sh_wait = SYNC, st_wait = SYNC;
   logic [W-1:0] exp_q[$];

   task automatic check(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // scoreboard monitor: each capture pushed by the driver is compared here
   always @(negedge st_clk) begin
      if (exp_q.size() > 0) begin
         logic [W-1:0] e;
         e = exp_q.pop_front();
         check(par_q === e, "R3 captured word", par_q, e);
      end
   end

   task automatic pulse(input bit do_sh, input bit do_st, input logic b);
      logic [W-1:0] old_sh, old_sh2;
      bit st_live;
      ser_in = b;
      #5;
      old_sh = sh_m; old_sh2 = sh2_m; st_live = 1'b0;
      if (do_sh && sh_clr_n) begin
         if (sh_wait > 0) sh_wait--;
         else begin
            sh_m  = {sh_m[W-2:0], b};
            sh2_m = {sh2_m[W-2:0], old_sh[W-1]};
         end
      end
      if (do_st) begin
         if (st_clr_n) begin
            if (st_wait > 0) st_wait--;
            else begin st_m = old_sh; st2_m = old_sh2; st_live = 1'b1; end
         end
         exp_q.push_back(st_m);
      end
      sh_clk = do_sh; st_clk = do_st;
      #5;
      if (do_sh) begin
         check(casc_out === sh_m[W-1], "R5 cascade", {7'b0, casc_out}, {7'b0, sh_m[W-1]});
         check(casc2 === sh2_m[W-1], "R8 chained cascade", {7'b0, casc2}, {7'b0, sh2_m[W-1]});
      end
      if (!do_st) check(par_q === st_m, "R3 shift edge leaves outputs", par_q, st_m);
      else check(par2 === st2_m, "R8 chained capture", par2, st2_m);
      if (do_sh && do_st && st_live) check(par_q === old_sh, "R6 tied-clock lag", par_q, old_sh);
      #5;
      sh_clk = 1'b0; st_clk = 1'b0;
      #5;
   endtask

   task automatic set_sh_clr(input logic v);
      sh_clr_n = v;
      #3;
      if (!v) begin
         sh_m = '0; sh2_m = '0;
         check(casc_out === 1'b0, "R1 clear empties chain", {7'b0, casc_out}, '0);
         check(casc2 === 1'b0, "R1 clear empties second chain", {7'b0, casc2}, '0);
      end else sh_wait = SYNC;
      #2;
   endtask

   task automatic set_st_clr(input logic v);
      logic c;
      c = casc_out;
      st_clr_n = v;
      #3;
      if (!v) begin
         st_m = '0; st2_m = '0;
         check(par_q === '0, "R4 clear empties outputs", par_q, '0);
         check(casc_out === c, "R4 shift chain untouched", {7'b0, casc_out}, {7'b0, c});
      end else st_wait = SYNC;
      #2;
   endtask

   task automatic shift_byte(input logic [W-1:0] v);
      for (int i = W - 1; i >= 0; i--) pulse(1'b1, 1'b0, v[i]);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #7;
      check(par_q === '0, "R4 reset outputs", par_q, '0);
      check(casc_out === 1'b0, "R1 reset cascade", {7'b0, casc_out}, '0);
      // R7: edges while both clears are low do nothing
      pulse(1'b1, 1'b1, 1'b1);
      pulse(1'b1, 1'b1, 1'b1);
      check(par_q === '0, "R7 edges ignored during clear", par_q, '0);
      set_sh_clr(1'b1);
      set_st_clr(1'b1);
      // R7: first SYNC edges after release do nothing
      pulse(1'b1, 1'b1, 1'b1);
      pulse(1'b1, 1'b1, 1'b1);
      pulse(1'b0, 1'b1, 1'b0);
      check(par_q === '0, "R7 release delay", par_q, '0);
      // R2/R3: random bytes, full shift then capture
      for (int n = 0; n < 8; n++) begin
         logic [W-1:0] v;
         v = W'($urandom);
         shift_byte(v);
         pulse(1'b0, 1'b1, 1'b0);
         check(par_q === v, "R2 byte order at outputs", par_q, v);
      end
      shift_byte(8'h01);
      pulse(1'b0, 1'b1, 1'b0);
      check(par_q === 8'h01, "R2 single bit lands in last stage order", par_q, 8'h01);
      // R6: tied clocks
      for (int n = 0; n < 12; n++) pulse(1'b1, 1'b1, 1'($urandom));
      // R1 mid-sequence
      pulse(1'b1, 1'b0, 1'b1);
      pulse(1'b1, 1'b0, 1'b1);
      set_sh_clr(1'b0);
      pulse(1'b1, 1'b0, 1'b1);
      pulse(1'b0, 1'b1, 1'b0);
      check(par_q === '0, "R1 capture of cleared chain", par_q, '0);
      set_sh_clr(1'b1);
      pulse(1'b1, 1'b0, 1'b1);
      pulse(1'b1, 1'b0, 1'b1);
      pulse(1'b0, 1'b1, 1'b0);
      check(par_q === '0, "R7 shift restart delay", par_q, '0);
      shift_byte(8'hA6);
      pulse(1'b0, 1'b1, 1'b0);
      check(par_q === 8'hA6, "R7 shift resumes", par_q, 8'hA6);
      // R4 mid-sequence
      shift_byte(8'h3C);
      set_st_clr(1'b0);
      pulse(1'b0, 1'b1, 1'b0);
      set_st_clr(1'b1);
      pulse(1'b0, 1'b1, 1'b0);
      pulse(1'b0, 1'b1, 1'b0);
      check(par_q === '0, "R7 storage restart delay", par_q, '0);
      pulse(1'b0, 1'b1, 1'b0);
      check(par_q === 8'h3C, "R4 chain kept through storage clear", par_q, 8'h3C);
      // R8: two-device chain
      shift_byte(8'h5A);
      shift_byte(8'hE1);
      pulse(1'b0, 1'b1, 1'b0);
      check(par2 === 8'h5A, "R8 second device word", par2, 8'h5A);
      check(par_q === 8'hE1, "R8 first device word", par_q, 8'hE1);
      #40;
      check(exp_q.size() == 0, "R3 scoreboard drained", W'(exp_q.size()), '0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule